// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two 64-bit operands, in signed or unsigned form. It also has word forms that take only the low 32 bits of each operand and return a 32-bit result sign-extended to 64 bits. No case raises an exception. A zero divisor and the one signed overflow case (the most negative value divided by -1) each return a fixed value, and the word forms apply the same rules at 32 bits.

A request is taken on a cycle where `req_valid` and `req_ready` are both high. It carries two operands and a 3-bit operation code. The special cases are found at request time and answered at once. Every other request runs a radix-2 restoring loop on the operand magnitudes, one quotient bit per cycle, and then corrects the sign of the result. The result appears on `rsp_data` with a one-cycle `rsp_valid` pulse. Only one division is in flight at a time.

Top module: `intdiv_unit`

## Requirements
- R1: The operation code is decoded by field: bit 2 selects the word form, bit 1 selects remainder instead of quotient, and bit 0 selects unsigned instead of signed. A quotient with a non-zero divisor is exact, and a signed quotient rounds toward zero.
- R2: A remainder with a non-zero divisor satisfies dividend = quotient × divisor + remainder. A signed remainder takes the sign of the dividend.
- R3: When the divisor is zero, every quotient operation, signed or unsigned, returns all ones in all 64 bits. This includes the word forms.
- R4: When the divisor is zero, a remainder returns the dividend. A full-width remainder returns all 64 bits of the dividend. A word remainder returns the low 32 bits of the dividend, sign-extended.
- R5: A signed quotient of the most negative value by -1 returns the most negative value, and the matching signed remainder returns 0. This holds at 64 bits, and at 32 bits for the word forms, where the word quotient is 0xFFFFFFFF80000000.
- R6: The word forms ignore operand bits 63..32. They sign-extend bit 31 of the 32-bit result into bits 63..32, and this applies to unsigned word results too.
- R7: A request with a zero divisor or the signed overflow case gives `rsp_valid` high in the cycle right after the accepting edge, and `req_ready` stays high.
- R8: Any other request drops `req_ready` until its result is out. `rsp_valid` rises on the 65th clock edge after the accepting edge for full-width operations and on the 33rd edge for word operations. `req_ready` is high whenever `rsp_valid` is high.
- R9: `rsp_valid` is a single-cycle pulse, and exactly one pulse follows each accepted request.
- R10: After a synchronous active-low reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | Operation: bit 2 word form, bit 1 remainder, bit 0 unsigned |
| req_a | input | 64 | Dividend |
| req_b | input | 64 | Divisor |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 64 | Result |

## Verification
Each result has a fixed due cycle. A zero-divisor or overflow result is due in the cycle right after the accepting edge. A full-width loop result is due on the 65th edge after the accepting edge, and a word loop result on the 33rd. The driver computes this due cycle from the operands alone and stores it in the scoreboard next to the expected value. The monitor samples on the falling edge and requires each pulse to land on exactly the stored cycle; a result that is late or missing counts as a timing failure. The driver also samples `req_ready` one cycle after each accept, so it sees whether the unit stayed free after a special case or went busy for a loop.

// File: rtl/intdiv_pkg.sv
// Package: shared types for the divide/remainder unit.
// Assumes a 3-bit operation code with independent fields.
package intdiv_pkg;

    localparam int OP_W = 3;

    // Operation code fields, MSB first: word form, remainder, unsigned
    typedef struct packed {
        logic word;
        logic rem;
        logic uns;
    } div_op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Control kept for the final correction of a loop result
    typedef struct packed {
        logic word;
        logic rem;
        logic neg_q;
        logic neg_r;
    } fix_ctl_t;

endpackage

// File: rtl/intdiv_prep.sv
// Module: intdiv_prep
// Narrows the operands for word forms, finds the zero-divisor and overflow
// cases with their fixed results, and forms the operand magnitudes and the
// result signs for the loop. Purely combinational. Assumes WLEN < XLEN.
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  div_op_t          op,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic             special,
    output logic [XLEN-1:0]  special_val,
    output logic [XLEN-1:0]  dvd_mag,
    output logic [XLEN-1:0]  dvs_mag,
    output logic             neg_q,
    output logic             neg_r
);
    localparam int EXT = XLEN - WLEN;
    localparam logic [XLEN-1:0] FULL_MIN = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] WORD_MIN = {{(EXT+1){1'b1}}, {(WLEN-1){1'b0}}};

    logic [XLEN-1:0] a_w, b_w, a_sx;
    logic            sign_a, sign_b, div_zero, a_is_min, ovf;

    // Extend the word operands by signedness; pass full-width operands through
    always_comb begin
        if (op.word) begin
            a_w = op.uns ? {{EXT{1'b0}}, opa[WLEN-1:0]} : {{EXT{opa[WLEN-1]}}, opa[WLEN-1:0]};
            b_w = op.uns ? {{EXT{1'b0}}, opb[WLEN-1:0]} : {{EXT{opb[WLEN-1]}}, opb[WLEN-1:0]};
            a_sx = {{EXT{opa[WLEN-1]}}, opa[WLEN-1:0]};
        end else begin
            a_w  = opa;
            b_w  = opb;
            a_sx = opa;
        end
    end

    // Find the special cases and their fixed results
    always_comb begin
        sign_a   = !op.uns && a_w[XLEN-1];
        sign_b   = !op.uns && b_w[XLEN-1];
        div_zero = (b_w == '0);
        a_is_min = op.word ? (a_w == WORD_MIN) : (a_w == FULL_MIN);
        ovf      = !op.uns && a_is_min && (b_w == '1);
        special  = div_zero || ovf;
        if (div_zero)
            special_val = op.rem ? a_sx : '1;
        else
            special_val = op.rem ? '0 : a_w;
    end

    // Magnitudes and the signs the final correction needs
    always_comb begin
        dvd_mag = sign_a ? (~a_w + 1'b1) : a_w;
        dvs_mag = sign_b ? (~b_w + 1'b1) : b_w;
        neg_q   = sign_a ^ sign_b;
        neg_r   = sign_a;
    end

endmodule

// File: rtl/intdiv_core.sv
// Module: intdiv_core
// Radix-2 restoring divider on unsigned magnitudes. start loads the operands;
// the unit then runs XLEN steps, or WLEN steps when word is set, one per cycle.
// done is high while no step is pending. Assumes the divisor is non-zero.
module intdiv_core #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word,
    input  logic [XLEN-1:0]  dvd,
    input  logic [XLEN-1:0]  dvs,
    output logic             done,
    output logic [XLEN-1:0]  quo,
    output logic [XLEN-1:0]  rem
);
    localparam int EXT = XLEN - WLEN;
    localparam int CW  = $clog2(XLEN + 1);

    logic [XLEN-1:0] rem_q, quo_q, dvs_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN:0]   trial, diff;
    logic            take;

    // One restoring step: shift in the next dividend bit and try to subtract
    always_comb begin
        trial = {rem_q, quo_q[XLEN-1]};
        diff  = trial - {1'b0, dvs_q};
        take  = (trial >= {1'b0, dvs_q});
    end

    // Load on start, then step until the counter runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            rem_q <= '0;
            quo_q <= word ? {dvd[WLEN-1:0], {EXT{1'b0}}} : dvd;
            dvs_q <= dvs;
            cnt_q <= word ? CW'(WLEN) : CW'(XLEN);
        end else if (cnt_q != '0) begin
            rem_q <= take ? diff[XLEN-1:0] : trial[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], take};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
    assign quo  = quo_q;
    assign rem  = rem_q;

endmodule

// File: rtl/intdiv_post.sv
// Module: intdiv_post
// Picks the quotient or the remainder, applies its sign, and sign-extends
// word results from bit WLEN-1. Purely combinational.
module intdiv_post
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  fix_ctl_t         ctl,
    input  logic [XLEN-1:0]  quo,
    input  logic [XLEN-1:0]  rem,
    output logic [XLEN-1:0]  res
);
    localparam int EXT = XLEN - WLEN;

    logic [XLEN-1:0] pick, val;
    logic            neg;

    // Select, negate, then widen
    always_comb begin
        pick = ctl.rem ? rem : quo;
        neg  = ctl.rem ? ctl.neg_r : ctl.neg_q;
        val  = neg ? (~pick + 1'b1) : pick;
        res  = ctl.word ? {{EXT{val[WLEN-1]}}, val[WLEN-1:0]} : val;
    end

endmodule

// File: rtl/intdiv_unit.sv
// Module: intdiv_unit (top)
// Handles the request/response handshake for the divider. A special case is
// answered in the cycle after it is accepted. Any other request starts the
// restoring loop and its result is registered when the loop finishes. Assumes
// the requester holds its request stable until req_ready accepts it.
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OP_W-1:0]  req_op,
    input  logic [XLEN-1:0]  req_a,
    input  logic [XLEN-1:0]  req_b,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_data
);
    div_op_t         op_in;
    div_state_e      state_q;
    fix_ctl_t        ctl_q;
    logic            special, neg_q, neg_r, accept, start, core_done;
    logic [XLEN-1:0] special_val, dvd_mag, dvs_mag, quo, rem, post_res;

    assign op_in     = div_op_t'(req_op);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign start     = accept && !special;

    intdiv_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
        .op          (op_in),
        .opa         (req_a),
        .opb         (req_b),
        .special     (special),
        .special_val (special_val),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .neg_q       (neg_q),
        .neg_r       (neg_r)
    );

    intdiv_core #(.XLEN(XLEN), .WLEN(WLEN)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (op_in.word),
        .dvd   (dvd_mag),
        .dvs   (dvs_mag),
        .done  (core_done),
        .quo   (quo),
        .rem   (rem)
    );

    intdiv_post #(.XLEN(XLEN), .WLEN(WLEN)) u_post (
        .ctl (ctl_q),
        .quo (quo),
        .rem (rem),
        .res (post_res)
    );

    // Sequencing and the registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ctl_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && special) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= special_val;
                    end else if (accept) begin
                        state_q <= ST_RUN;
                        ctl_q   <= '{word: op_in.word, rem: op_in.rem,
                                     neg_q: neg_q, neg_r: neg_r};
                    end
                end
                ST_RUN: begin
                    if (core_done) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= post_res;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/intdiv_unit_chk.sv
// Module: intdiv_unit_chk
// Property checker for intdiv_unit, attached by bind. It watches the ports
// and keeps its own record of the form of the last accepted request.
module intdiv_unit_chk #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic [XLEN-1:0]  req_a,
    input logic [XLEN-1:0]  req_b,
    input logic             rsp_valid,
    input logic [XLEN-1:0]  rsp_data
);
    localparam logic [XLEN-1:0] FULL_MIN = {1'b1, {(XLEN-1){1'b0}}};

    logic acc, b_zero, word_seen;

    assign acc    = req_valid && req_ready;
    assign b_zero = req_op[2] ? (req_b[WLEN-1:0] == '0) : (req_b == '0);

    // Remember whether the request in flight is a word form
    always_ff @(posedge clk) begin
        if (!rst_n) word_seen <= 1'b0;
        else if (acc) word_seen <= req_op[2];
    end

    AST_ZERO_DIV_Q: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_op[1] && b_zero |=> rsp_valid && (rsp_data == '1)); // R3

    AST_ZERO_REM: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op[1] && !req_op[2] && b_zero |=> rsp_valid && (rsp_data == $past(req_a))); // R4

    AST_OVF_REM: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (req_op == 3'd2) && (req_a == FULL_MIN) && (req_b == '1) |=> rsp_valid && (rsp_data == '0)); // R5

    AST_SPECIAL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && b_zero |=> req_ready); // R7

    AST_READY_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R8

    AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && word_seen |-> (rsp_data[XLEN-1:WLEN] == {(XLEN-WLEN){rsp_data[WLEN-1]}})); // R6

endmodule

bind intdiv_unit intdiv_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_a     (req_a),
    .req_b     (req_b),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/tb_intdiv_unit.sv
`timescale 1ns/1ps
module tb_intdiv_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit live   = 1'b0;

    typedef struct {
        logic [63:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t sb[$];

    intdiv_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_a(req_a), .req_b(req_b),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        logic [31:0] a32, b32, r32;
        if (!op[2]) begin
            if (b == 0) r = op[1] ? a : '1;
            else if (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1) r = op[1] ? 64'd0 : a;
            else if (op[0]) r = op[1] ? (a % b) : (a / b);
            else if (op[1]) r = $signed(a) % $signed(b);
            else r = $signed(a) / $signed(b);
        end else begin
            a32 = a[31:0];
            b32 = b[31:0];
            if (b32 == 0) r32 = op[1] ? a32 : '1;
            else if (!op[0] && a32 == 32'h8000_0000 && b32 == '1) r32 = op[1] ? 32'd0 : a32;
            else if (op[0]) r32 = op[1] ? (a32 % b32) : (a32 / b32);
            else if (op[1]) r32 = $signed(a32) % $signed(b32);
            else r32 = $signed(a32) / $signed(b32);
            r = {{32{r32[31]}}, r32};
        end
        return r;
    endfunction

    function automatic bit is_special(logic [2:0] op, logic [63:0] a, logic [63:0] b);
        if (op[2])
            return (b[31:0] == 0) || (!op[0] && a[31:0] == 32'h8000_0000 && b[31:0] == '1);
        return (b == 0) || (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one request, push its expected result and due cycle
    task automatic drive(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
        item_t it;
        bit    sp;
        @(negedge clk);
        req_valid = 1'b1;
        req_op = op;
        req_a = a;
        req_b = b;
        while (!req_ready) @(negedge clk);
        sp = is_special(op, a, b);
        it.exp = model(op, a, b);
        it.due = cyc + 1 + (sp ? 0 : (op[2] ? 33 : 65));
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        if (sp) check(req_ready == 1'b1, "R7 ready after special", 64'(req_ready), 64'd1);
        else    check(req_ready == 1'b0, "R8 busy during loop", 64'(req_ready), 64'd0);
    endtask

    // Monitor: compare each response with the head of the scoreboard
    always @(negedge clk) begin
        if (live) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 response without request", rsp_data, 64'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(rsp_data == it.exp, it.tag, rsp_data, it.exp);
                    check(cyc == it.due, "R8 result timing", 64'(cyc), 64'(it.due));
                end
            end else if (sb.size() > 0 && cyc > sb[0].due) begin
                check(1'b0, "R8 result missing at due cycle", 64'(cyc), 64'(sb[0].due));
                void'(sb.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R10 no response after reset", 64'(rsp_valid), 64'd0);
        live = 1'b1;

        // R1 / R2 signed and unsigned, all sign combinations
        drive(3'd0, 64'd100, 64'd7, "R1 div 100/7");
        drive(3'd2, 64'd100, 64'd7, "R2 rem 100%7");
        drive(3'd0, -64'sd100, 64'd7, "R1 div -100/7 toward zero");
        drive(3'd2, -64'sd100, 64'd7, "R2 rem sign of dividend");
        drive(3'd0, 64'd100, -64'sd7, "R1 div 100/-7");
        drive(3'd2, 64'd100, -64'sd7, "R2 rem 100%-7");
        drive(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R1 unsigned div max/3");
        drive(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, "R2 unsigned rem max%10");
        drive(3'd0, 64'h8000_0000_0000_0000, 64'd1, "R1 div min/1");
        drive(3'd0, 64'd5, -64'sd1, "R1 div 5/-1");
        // R3 / R4 zero divisor
        drive(3'd0, 64'd42, 64'd0, "R3 signed div by zero");
        drive(3'd1, 64'd42, 64'd0, "R3 unsigned div by zero");
        drive(3'd2, 64'hDEAD_BEEF_0000_1234, 64'd0, "R4 signed rem by zero");
        drive(3'd3, 64'h8000_0000_0000_0001, 64'd0, "R4 unsigned rem by zero");
        drive(3'd5, 64'd9, 64'hFFFF_FFFF_0000_0000, "R3 unsigned word div by zero");
        drive(3'd7, 64'h1234_5678_8000_0001, 64'h7_0000_0000, "R4 word rem by zero sign-extended");
        // R5 overflow
        drive(3'd0, 64'h8000_0000_0000_0000, '1, "R5 div overflow");
        drive(3'd2, 64'h8000_0000_0000_0000, '1, "R5 rem overflow");
        drive(3'd4, 64'h0000_0001_8000_0000, 64'h0000_0002_FFFF_FFFF, "R5 word div overflow");
        drive(3'd6, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5 word rem overflow");
        // R6 word forms with bit 31 set and upper bits ignored
        drive(3'd5, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001, "R6 unsigned word div bit31");
        drive(3'd7, 64'h0000_0001_8000_0000, 64'h5555_5555_FFFF_FFFF, "R6 unsigned word rem bit31");
        drive(3'd4, 64'hFFFF_FFFF_FFFF_FF9C, 64'h0000_0000_0000_0007, "R6 signed word div -100/7");
        drive(3'd6, 64'h7777_7777_FFFF_FF9C, 64'h0000_0000_0000_0007, "R6 signed word rem -100%7");

        // Random operands across all operations
        for (int i = 0; i < 60; i++) begin
            logic [2:0]  op;
            logic [63:0] a, b;
            string       tg;
            op = 3'($urandom % 8);
            a  = {$urandom(), $urandom()};
            case (i % 4)
                0: b = 64'($urandom % 16) - 64'd8;
                1: b = {32'($urandom), 32'($urandom)};
                2: b = {32'd0, 32'($urandom)};
                default: b = 64'($urandom % 1000);
            endcase
            tg = op[2] ? "R6 random word" : (op[1] ? "R2 random rem" : "R1 random div");
            drive(op, a, b, tg);
        end

        while (sb.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule